// File: doc/BRIEF.md
# Tagged Next-Address Predictor with Direction Counters

This block supplies the fetch stage with a guess of the next program counter before the instruction has been decoded. It is a direct-mapped table of 2^IDX_W slots. Each slot holds a valid flag, the full address of a control-transfer instruction, the target that instruction last went to, and a 2-bit saturating direction counter. A fetch address is looked up combinationally. The stored target is returned only when the full address matches and the counter leans taken. In every other case the sequential address (fetch address plus 4) is returned.

The execute stage reports each resolved instruction through the update port: its address, its actual target, whether it was taken, and whether it is a branch or jump. Only branches and jumps change the table, so ordinary arithmetic instructions never take over a slot. A report that misses its slot replaces the slot's contents and starts its counter in a weak state. A report that hits the slot moves the counter one step. The target is only refreshed by a taken outcome. Decode, branch resolution, pipeline kill logic and global history all lie outside this block.

Top module: `nap_predictor`

## Requirements
- R1: The slot for an address `a` is `a[IDX_W+1:2]`. Two addresses with equal slot bits compete for one slot, so allocating one evicts the other.
- R2: A lookup hits only when the slot is valid and its stored address equals the full fetch address. On a miss, `pred_pc` is `fetch_pc + 4`.
- R3: On a hit, `pred_pc` is the stored target when counter bit 1 is 1 (values 2'b10 and 2'b11). When that bit is 0 (values 2'b00 and 2'b01), `pred_pc` is `fetch_pc + 4`.
- R4: A clock edge with `upd_en` high and `upd_is_ctrl` low changes no slot. Only reports with both signals high modify the table.
- R5: A control report that misses its slot makes the slot valid and writes the address and target. It sets the counter to 2'b10 when taken and to 2'b01 when not taken.
- R6: A control report that hits its slot increments the counter when taken, stopping at 2'b11. It decrements the counter when not taken, stopping at 2'b00.
- R7: A hitting control report replaces the stored target only when taken. A not-taken hit leaves the target unchanged.
- R8: The lookup is combinational. A report applied at clock edge N affects lookups only after that edge, and a lookup in the same cycle as the report sees the old contents.
- R9: A synchronous reset (`rst` high at a clock edge) invalidates every slot, so every later lookup returns `fetch_pc + 4` until new reports arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | ADDR_W | Address being fetched |
| pred_pc | output | ADDR_W | Predicted next fetch address |
| upd_en | input | 1 | A resolved instruction report is present |
| upd_pc | input | ADDR_W | Address of the resolved instruction |
| upd_target | input | ADDR_W | Actual target of the resolved instruction |
| upd_taken | input | 1 | The resolved instruction redirected flow |
| upd_is_ctrl | input | 1 | The resolved instruction is a branch or jump |

## Verification
The assertions assume that every field of a report is known whenever `upd_en` is high. They also assume that `upd_taken` is meaningful only for control reports, and that the fetch address is word aligned. The stimulus changes inputs only on falling edges and holds `upd_en` for exactly one rising edge per report. It only reports word-aligned addresses, and it keeps `fetch_pc` fixed between lookups. It walks a single slot through allocation, both saturation limits, aliasing eviction and a same-cycle report. This means every counter transition the assertions watch is reached with defined inputs.

// File: rtl/nap_pkg.sv
package nap_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // Saturating step of the direction counter.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

    // Weak starting state for a freshly claimed slot.
    function automatic ctr_t ctr_seed(input logic taken);
        return taken ? CTR_WEAK_T : CTR_WEAK_NT;
    endfunction

    // Counter leans taken when its upper bit is set.
    function automatic logic ctr_leans_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/nap_table.sv
module nap_table
    import nap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [ADDR_W-1:0] rd_tag,
    output logic [ADDR_W-1:0] rd_tgt,
    output ctr_t              rd_ctr,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    input  logic              upd_is_ctrl
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] tag;
        logic [ADDR_W-1:0] tgt;
        ctr_t              ctr;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
    } state_t;

    state_t            st_d, st_q;
    logic [IDX_W-1:0]  wr_idx;
    slot_t             wr_cur;
    logic              wr_hit;
    logic              wr_go;

    always_comb begin
        st_d   = st_q;
        wr_idx = upd_pc[IDX_W+1:2];
        wr_cur = st_q.slots[wr_idx];
        wr_hit = wr_cur.vld && (wr_cur.tag == upd_pc);
        wr_go  = upd_en && upd_is_ctrl;
        if (wr_go) begin
            if (wr_hit) begin
                st_d.slots[wr_idx].ctr = ctr_step(wr_cur.ctr, upd_taken);
                if (upd_taken) begin
                    st_d.slots[wr_idx].tgt = upd_target;
                end
            end else begin
                st_d.slots[wr_idx].vld = 1'b1;
                st_d.slots[wr_idx].tag = upd_pc;
                st_d.slots[wr_idx].tgt = upd_target;
                st_d.slots[wr_idx].ctr = ctr_seed(upd_taken);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vld = st_q.slots[rd_idx].vld;
    assign rd_tag = st_q.slots[rd_idx].tag;
    assign rd_tgt = st_q.slots[rd_idx].tgt;
    assign rd_ctr = st_q.slots[rd_idx].ctr;

    // Slot written at the previous edge, kept for the checks below.
    logic [IDX_W-1:0] chk_idx_q;
    always_ff @(posedge clk) begin
        chk_idx_q <= wr_idx;
    end

    AST_IGNORE_NONCTRL: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_is_ctrl) |=> $stable(st_q)); // R4

    AST_ALLOC_SEED: assert property (@(posedge clk) disable iff (rst)
        (wr_go && !wr_hit) |=> (st_q.slots[chk_idx_q].vld &&
            st_q.slots[chk_idx_q].ctr == ($past(upd_taken) ? CTR_WEAK_T : CTR_WEAK_NT))); // R5

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr_go && wr_hit && upd_taken && wr_cur.ctr == CTR_STRONG_T)
        |=> (st_q.slots[chk_idx_q].ctr == CTR_STRONG_T)); // R6

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr_go && wr_hit && !upd_taken && wr_cur.ctr == CTR_STRONG_NT)
        |=> (st_q.slots[chk_idx_q].ctr == CTR_STRONG_NT)); // R6

    AST_KEEP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (wr_go && wr_hit && !upd_taken)
        |=> (st_q.slots[chk_idx_q].tgt == $past(wr_cur.tgt))); // R7

endmodule

// File: rtl/nap_lookup.sv
module nap_lookup
    import nap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              ent_vld,
    input  logic [ADDR_W-1:0] ent_tag,
    input  logic [ADDR_W-1:0] ent_tgt,
    input  ctr_t              ent_ctr,
    output logic [ADDR_W-1:0] pred_pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic tag_hit;
    logic use_tgt;

    always_comb begin
        tag_hit = ent_vld && (ent_tag == fetch_pc);
        use_tgt = tag_hit && ctr_leans_taken(ent_ctr);
        pred_pc = use_tgt ? ent_tgt : (fetch_pc + STEP);
    end

endmodule

// File: rtl/nap_predictor.sv
module nap_predictor
    import nap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] pred_pc,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    input  logic              upd_is_ctrl
);

    logic [IDX_W-1:0]  look_idx;
    logic              ent_vld;
    logic [ADDR_W-1:0] ent_tag;
    logic [ADDR_W-1:0] ent_tgt;
    ctr_t              ent_ctr;

    assign look_idx = fetch_pc[IDX_W+1:2];

    nap_table #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_table (
        .clk         (clk),
        .rst         (rst),
        .rd_idx      (look_idx),
        .rd_vld      (ent_vld),
        .rd_tag      (ent_tag),
        .rd_tgt      (ent_tgt),
        .rd_ctr      (ent_ctr),
        .upd_en      (upd_en),
        .upd_pc      (upd_pc),
        .upd_target  (upd_target),
        .upd_taken   (upd_taken),
        .upd_is_ctrl (upd_is_ctrl)
    );

    nap_lookup #(
        .ADDR_W (ADDR_W)
    ) u_lookup (
        .fetch_pc (fetch_pc),
        .ent_vld  (ent_vld),
        .ent_tag  (ent_tag),
        .ent_tgt  (ent_tgt),
        .ent_ctr  (ent_ctr),
        .pred_pc  (pred_pc)
    );

endmodule

// File: tb/nap_predictor_tb.sv
module nap_predictor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] fetch_pc = '0;
    logic [AW-1:0] pred_pc;
    logic          upd_en = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_target = '0;
    logic          upd_taken = 1'b0;
    logic          upd_is_ctrl = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [AW-1:0] q_exp[$];
    logic [AW-1:0] q_pc[$];
    string         q_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nap_predictor #(.ADDR_W(AW), .IDX_W(6)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .fetch_pc    (fetch_pc),
        .pred_pc     (pred_pc),
        .upd_en      (upd_en),
        .upd_pc      (upd_pc),
        .upd_target  (upd_target),
        .upd_taken   (upd_taken),
        .upd_is_ctrl (upd_is_ctrl)
    );

    // Driver: present a fetch address and queue the expected prediction.
    task automatic look(input logic [AW-1:0] pc, input logic [AW-1:0] exp, input string req);
        @(negedge clk);
        fetch_pc = pc;
        q_exp.push_back(exp);
        q_pc.push_back(pc);
        q_req.push_back(req);
    endtask

    // Driver: one resolved-instruction report, held for one rising edge.
    task automatic report(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                          input logic taken, input logic ctrl);
        @(negedge clk);
        upd_en = 1'b1; upd_pc = pc; upd_target = tgt;
        upd_taken = taken; upd_is_ctrl = ctrl;
        @(posedge clk);
        #1 upd_en = 1'b0;
    endtask

    // Monitor: compare after inputs settle, before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [AW-1:0] e, p;
                string r;
                e = q_exp.pop_front();
                p = q_pc.pop_front();
                r = q_req.pop_front();
                total++;
                if (pred_pc !== e) begin
                    bad++;
                    $display("FAIL %s pc=%h actual=%h expected=%h", r, p, pred_pc, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // Reset state: empty table predicts sequential (R9, R2)
        look(32'h0000_0100, 32'h0000_0104, "R9");
        look(32'h0000_0000, 32'h0000_0004, "R2");

        // Non-control report ignored (R4)
        report(32'h100, 32'h500, 1'b1, 1'b0);
        look(32'h100, 32'h104, "R4");

        // Taken allocation seeds weak-taken (R5, R3)
        report(32'h100, 32'h500, 1'b1, 1'b1);
        look(32'h100, 32'h500, "R5");
        look(32'h200, 32'h204, "R2 tag mismatch same slot");

        // Not-taken hit: 10->01, target kept (R6, R7, R3)
        report(32'h100, 32'h999, 1'b0, 1'b1);
        look(32'h100, 32'h104, "R3 weak not-taken");
        // Taken hit: 01->10, target replaced (R7)
        report(32'h100, 32'h600, 1'b1, 1'b1);
        look(32'h100, 32'h600, "R7 taken replaces");
        // 10->11->11 saturation, then one step down stays taken (R6)
        report(32'h100, 32'h600, 1'b1, 1'b1);
        report(32'h100, 32'h600, 1'b1, 1'b1);
        report(32'h100, 32'h998, 1'b0, 1'b1);
        look(32'h100, 32'h600, "R6 saturate high");
        report(32'h100, 32'h600, 1'b0, 1'b1);
        look(32'h100, 32'h104, "R6 down to weak not-taken");
        // 01->00->00, then one taken -> 01 (R6 low end)
        report(32'h100, 32'h600, 1'b0, 1'b1);
        report(32'h100, 32'h600, 1'b0, 1'b1);
        report(32'h100, 32'h600, 1'b1, 1'b1);
        look(32'h100, 32'h104, "R6 saturate low");
        report(32'h100, 32'h600, 1'b1, 1'b1);
        look(32'h100, 32'h600, "R6 climb from low");

        // Aliasing: 0x200 shares the slot of 0x100 (R1, R5)
        report(32'h200, 32'h800, 1'b0, 1'b1);
        look(32'h200, 32'h204, "R5 seed not-taken");
        look(32'h100, 32'h104, "R1 evicted");
        report(32'h200, 32'h800, 1'b1, 1'b1);
        look(32'h200, 32'h800, "R5 weak seed one step");

        // Separate slot is independent (R1)
        report(32'h104, 32'h40, 1'b1, 1'b1);
        look(32'h104, 32'h40, "R1 other slot");
        look(32'h200, 32'h800, "R1 untouched slot");

        // Same-cycle report is not visible until after the edge (R8)
        @(negedge clk);
        fetch_pc = 32'h108;
        q_exp.push_back(32'h10C); q_pc.push_back(32'h108); q_req.push_back("R8 same cycle");
        upd_en = 1'b1; upd_pc = 32'h108; upd_target = 32'h3000;
        upd_taken = 1'b1; upd_is_ctrl = 1'b1;
        @(posedge clk);
        #1 upd_en = 1'b0;
        look(32'h108, 32'h3000, "R8 next cycle");

        // Reset invalidates everything (R9)
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        look(32'h200, 32'h204, "R9 cleared");
        look(32'h108, 32'h10C, "R9 cleared other");

        @(negedge clk);
        #3;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule